// File: doc/BRIEF.md
# Compare-and-Branch Fusion Stage

This stage sits after instruction decode and before rename. It receives one decoded instruction per cycle. Each instruction carries an operation class, a condition code and a sequence tag. When a flag-producing instruction is followed directly by a conditional jump, and the active rule set allows the pair, the stage replaces the two with a single fused micro-op. That micro-op carries the producer's class, the jump's condition and both tags. Both the input and the output use valid/ready handshakes.

A fusible producer waits in a one-entry hold slot for one cycle, so that the stage can look at the next instruction. If no legal partner shows up, the producer leaves unfused, and program order is preserved. An increment or decrement does not write the carry flag. When one of these is followed directly by a jump that reads carry, the stage inserts a flag-merge micro-op between the two. A two-bit mode input selects the rule set. A long-mode input disables fusion completely in the legacy rule set.

Top module: `mop_fuse_unit`

## Requirements
- R1: After reset the output valid is low and the input ready is high.
- R2: In mode 0 (full), classes cmp (1), add (2) and sub (3) fuse with a jump (class 15) that immediately follows. The condition field is cond[3:1] = family and cond[0] = inverse. Legal families are carry (1), zero (2), below-or-equal (3), less (6) and less-or-equal (7), in either polarity. Families overflow (0), sign (4) and parity (5) never fuse with these classes.
- R3: In mode 0, classes test (8) and and (9) fuse with a jump of any condition.
- R4: In mode 0, inc (6) and dec (7) fuse only with the zero, less and less-or-equal families.
- R5: The following classes never fuse in any mode: adc (4), sbb (5), or (10), xor (11), not (12), neg (13), shift/rotate (14), no-flag (0) and jump (15).
- R6: In mode 1 (narrow), only cmp and test fuse, and they fuse with any condition.
- R7: In mode 2 (legacy), nothing fuses while long-mode is high. While long-mode is low, only cmp and test fuse, with the families listed in R2.
- R8: In mode 3, nothing fuses.
- R9: A jump that arrives one or more idle input cycles after the producer is accepted is not paired with it. The producer is emitted alone.
- R10: In every mode, an inc or dec followed immediately by a jump of family carry or below-or-equal produces three micro-ops in order. The first is the producer. The second is a merge micro-op with class 0, merge flag set, and the jump's condition and tag. The third is the jump.
- R11: A fused micro-op carries the producer's class and tag, the jump's condition, the jump's tag in the second tag field, the fused flag set and the merge flag clear. Unfused micro-ops have a second tag of 0.
- R12: Under output backpressure, no instruction is lost, duplicated or reordered. The output count equals the input count, minus fused pairs, plus merges.
- R13: While output valid is high and output ready is low, the output stays valid and its payload does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Rule set: 0 full, 1 narrow, 2 legacy, 3 off |
| long64_i | input | 1 | Long-mode flag, used by the legacy rule set |
| in_valid_i | input | 1 | Input instruction valid |
| in_ready_o | output | 1 | Stage can accept an input instruction |
| in_cls_i | input | 4 | Operation class of the input instruction |
| in_cond_i | input | 4 | Condition code (family in bits 3:1, inverse in bit 0) |
| in_tag_i | input | TAG_W | Sequence tag of the input instruction |
| out_valid_o | output | 1 | Output micro-op valid |
| out_ready_i | input | 1 | Consumer accepts the output micro-op |
| out_cls_o | output | 4 | Class of the micro-op (producer class when fused) |
| out_cond_o | output | 4 | Condition code (jump condition when fused or merge) |
| out_tag_o | output | TAG_W | Tag of the first instruction covered |
| out_jtag_o | output | TAG_W | Tag of the fused jump, 0 otherwise |
| out_fused_o | output | 1 | Micro-op is a fused pair |
| out_merge_o | output | 1 | Micro-op is an inserted flag merge |

## Verification
The bench builds the stage with TAG_W = 8 and merge insertion enabled. Eight-bit tags are wide enough for each stream's tags to stay distinct within a 256-item window, so a swapped or duplicated micro-op appears as a tag mismatch. Enabling merge insertion makes the three-micro-op sequences reachable in every rule set. Full sweeps cross all sixteen classes with all sixteen conditions in every mode. A mixed stream with random idle gaps and random backpressure exercises the one-cycle wait and the stall behaviour together.

// File: rtl/mop_fuse_pkg.sv
package mop_fuse_pkg;
  localparam int CLS_W = 4;
  localparam int CC_W  = 4;
  localparam int FAM_W = CC_W - 1;

  typedef enum logic [CLS_W-1:0] {
    OC_NONE  = 4'd0,  OC_CMP  = 4'd1,  OC_ADD  = 4'd2,  OC_SUB   = 4'd3,
    OC_ADC   = 4'd4,  OC_SBB  = 4'd5,  OC_INC  = 4'd6,  OC_DEC   = 4'd7,
    OC_TEST  = 4'd8,  OC_AND  = 4'd9,  OC_OR   = 4'd10, OC_XOR   = 4'd11,
    OC_NOT   = 4'd12, OC_NEG  = 4'd13, OC_SHROT = 4'd14, OC_JCC  = 4'd15
  } opcls_e;

  typedef enum logic [1:0] {
    FM_FULL = 2'd0, FM_NARROW = 2'd1, FM_LEGACY = 2'd2, FM_OFF = 2'd3
  } fmode_e;

  // condition families (cond[3:1])
  localparam logic [FAM_W-1:0] FAM_OVF  = 3'd0;
  localparam logic [FAM_W-1:0] FAM_CRY  = 3'd1;
  localparam logic [FAM_W-1:0] FAM_ZER  = 3'd2;
  localparam logic [FAM_W-1:0] FAM_BEQ  = 3'd3;
  localparam logic [FAM_W-1:0] FAM_SGN  = 3'd4;
  localparam logic [FAM_W-1:0] FAM_PAR  = 3'd5;
  localparam logic [FAM_W-1:0] FAM_LES  = 3'd6;
  localparam logic [FAM_W-1:0] FAM_LEQ  = 3'd7;
endpackage

// File: rtl/mop_fuse_rules.sv
module mop_fuse_rules
  import mop_fuse_pkg::*;
#(
  parameter bit MERGE_EN = 1'b1
) (
  input  logic [1:0]       mode_i,
  input  logic             long64_i,
  input  logic [CLS_W-1:0] head_cls_i,
  input  logic [CLS_W-1:0] next_cls_i,
  input  logic [FAM_W-1:0] next_fam_i,
  output logic             wait_o,
  output logic             fuse_o,
  output logic             merge_o
);
  logic is_cas, is_tan, is_idc, is_cmt, next_jcc;
  logic fam_arith, fam_idc, fam_cry;
  logic cand, legal, merge_wait;

  assign is_cas   = (head_cls_i == OC_CMP) || (head_cls_i == OC_ADD) || (head_cls_i == OC_SUB);
  assign is_tan   = (head_cls_i == OC_TEST) || (head_cls_i == OC_AND);
  assign is_idc   = (head_cls_i == OC_INC) || (head_cls_i == OC_DEC);
  assign is_cmt   = (head_cls_i == OC_CMP) || (head_cls_i == OC_TEST);
  assign next_jcc = (next_cls_i == OC_JCC);

  assign fam_arith = (next_fam_i != FAM_OVF) && (next_fam_i != FAM_SGN) && (next_fam_i != FAM_PAR);
  assign fam_idc   = (next_fam_i == FAM_ZER) || (next_fam_i == FAM_LES) || (next_fam_i == FAM_LEQ);
  assign fam_cry   = (next_fam_i == FAM_CRY) || (next_fam_i == FAM_BEQ);

  always_comb begin
    cand  = 1'b0;
    legal = 1'b0;
    unique case (fmode_e'(mode_i))
      FM_FULL: begin
        cand  = is_cas | is_tan | is_idc;
        legal = (is_cas & fam_arith) | is_tan | (is_idc & fam_idc);
      end
      FM_NARROW: begin
        cand  = is_cmt;
        legal = is_cmt;
      end
      FM_LEGACY: begin
        cand  = is_cmt & ~long64_i;
        legal = is_cmt & ~long64_i & fam_arith;
      end
      default: begin
        cand  = 1'b0;
        legal = 1'b0;
      end
    endcase
  end

  generate
    if (MERGE_EN) begin : g_merge
      assign merge_wait = is_idc;
      assign merge_o    = is_idc & next_jcc & fam_cry;
    end else begin : g_nomerge
      assign merge_wait = 1'b0;
      assign merge_o    = 1'b0;
    end
  endgenerate

  assign wait_o = cand | merge_wait;
  assign fuse_o = legal & next_jcc;
endmodule

// File: rtl/mop_fuse_ctrl.sv
module mop_fuse_ctrl
  import mop_fuse_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [CLS_W-1:0] in_cls_i,
  input  logic [CC_W-1:0]  in_cond_i,
  input  logic [TAG_W-1:0] in_tag_i,
  input  logic             wait_i,
  input  logic             fuse_i,
  input  logic             merge_i,
  output logic [CLS_W-1:0] hold_cls_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [CLS_W-1:0] out_cls_o,
  output logic [CC_W-1:0]  out_cond_o,
  output logic [TAG_W-1:0] out_tag_o,
  output logic [TAG_W-1:0] out_jtag_o,
  output logic             out_fused_o,
  output logic             out_merge_o
);
  logic             hold_v_q, hold_v_d;
  logic             pre_q, pre_d;
  logic             aged_q, aged_d;
  logic             load;
  logic [CLS_W-1:0] hcls_q;
  logic [CC_W-1:0]  hcc_q;
  logic [TAG_W-1:0] htag_q;
  logic             decided, take, fire, pair, mrg;

  assign hold_cls_o = hcls_q;

  assign decided     = pre_q | ~wait_i | aged_q | in_valid_i;
  assign out_valid_o = hold_v_q & decided;
  assign in_ready_o  = ~hold_v_q | (out_ready_i & ~pre_q);
  assign take        = in_valid_i & in_ready_o;
  assign fire        = out_valid_o & out_ready_i;
  assign pair        = hold_v_q & ~pre_q & ~aged_q & in_valid_i & fuse_i;
  assign mrg         = hold_v_q & ~pre_q & ~aged_q & in_valid_i & merge_i;

  // next state
  always_comb begin
    hold_v_d = hold_v_q;
    pre_d    = pre_q;
    aged_d   = aged_q;
    load     = 1'b0;
    if (!hold_v_q) begin
      if (take) begin
        hold_v_d = 1'b1;
        load     = 1'b1;
        pre_d    = 1'b0;
        aged_d   = 1'b0;
      end
    end else if (pre_q) begin
      if (fire) pre_d = 1'b0;
    end else if (fire) begin
      if (pair) begin
        hold_v_d = 1'b0;
      end else if (take) begin
        load   = 1'b1;
        pre_d  = mrg;
        aged_d = 1'b0;
      end else begin
        hold_v_d = 1'b0;
      end
    end else if (wait_i && !in_valid_i) begin
      aged_d = 1'b1;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      pre_q    <= 1'b0;
      aged_q   <= 1'b0;
    end else begin
      hold_v_q <= hold_v_d;
      pre_q    <= pre_d;
      aged_q   <= aged_d;
    end
  end

  // datapath registers, enabled by load
  always_ff @(posedge clk) begin
    if (load) begin
      hcls_q <= in_cls_i;
      hcc_q  <= in_cond_i;
      htag_q <= in_tag_i;
    end
  end

  // output formatting
  always_comb begin
    out_cls_o   = hcls_q;
    out_cond_o  = hcc_q;
    out_tag_o   = htag_q;
    out_jtag_o  = '0;
    out_fused_o = 1'b0;
    out_merge_o = 1'b0;
    if (pre_q) begin
      out_cls_o   = OC_NONE;
      out_merge_o = 1'b1;
    end else if (pair) begin
      out_cond_o  = in_cond_i;
      out_jtag_o  = in_tag_i;
      out_fused_o = 1'b1;
    end
  end
endmodule

// File: rtl/mop_fuse_unit.sv
module mop_fuse_unit
  import mop_fuse_pkg::*;
#(
  parameter int TAG_W    = 8,
  parameter bit MERGE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             long64_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [CLS_W-1:0] in_cls_i,
  input  logic [CC_W-1:0]  in_cond_i,
  input  logic [TAG_W-1:0] in_tag_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [CLS_W-1:0] out_cls_o,
  output logic [CC_W-1:0]  out_cond_o,
  output logic [TAG_W-1:0] out_tag_o,
  output logic [TAG_W-1:0] out_jtag_o,
  output logic             out_fused_o,
  output logic             out_merge_o
);
  logic [CLS_W-1:0] hold_cls;
  logic             wait_s, fuse_s, merge_s;

  mop_fuse_rules #(.MERGE_EN(MERGE_EN)) u_rules (
    .mode_i     (mode_i),
    .long64_i   (long64_i),
    .head_cls_i (hold_cls),
    .next_cls_i (in_cls_i),
    .next_fam_i (in_cond_i[CC_W-1:1]),
    .wait_o     (wait_s),
    .fuse_o     (fuse_s),
    .merge_o    (merge_s)
  );

  mop_fuse_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_cls_i    (in_cls_i),
    .in_cond_i   (in_cond_i),
    .in_tag_i    (in_tag_i),
    .wait_i      (wait_s),
    .fuse_i      (fuse_s),
    .merge_i     (merge_s),
    .hold_cls_o  (hold_cls),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_cls_o   (out_cls_o),
    .out_cond_o  (out_cond_o),
    .out_tag_o   (out_tag_o),
    .out_jtag_o  (out_jtag_o),
    .out_fused_o (out_fused_o),
    .out_merge_o (out_merge_o)
  );
endmodule

// File: rtl/mop_fuse_unit_chk.sv
module mop_fuse_unit_chk
  import mop_fuse_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             long64_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [CLS_W-1:0] out_cls_o,
  input logic [CC_W-1:0]  out_cond_o,
  input logic [TAG_W-1:0] out_tag_o,
  input logic [TAG_W-1:0] out_jtag_o,
  input logic             out_fused_o,
  input logic             out_merge_o
);
  logic fire, last_idc_q, last_mrg_q;
  assign fire = out_valid_o & out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idc_q <= 1'b0;
      last_mrg_q <= 1'b0;
    end else if (fire) begin
      last_idc_q <= ((out_cls_o == OC_INC) || (out_cls_o == OC_DEC)) && !out_fused_o && !out_merge_o;
      last_mrg_q <= out_merge_o;
    end
  end

  p_stall_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o &&
      $stable({out_cls_o, out_cond_o, out_tag_o, out_jtag_o, out_fused_o, out_merge_o}));

  p_merge_after_idc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_merge_o |-> last_idc_q);

  p_jump_after_merge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last_mrg_q |-> (out_cls_o == OC_JCC) && !out_fused_o && !out_merge_o &&
      ((out_cond_o[CC_W-1:1] == FAM_CRY) || (out_cond_o[CC_W-1:1] == FAM_BEQ)));

  p_never_fuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_fused_o |-> out_cls_o inside {OC_CMP, OC_ADD, OC_SUB, OC_INC, OC_DEC, OC_TEST, OC_AND});

  p_narrow_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_fused_o && (mode_i == FM_NARROW) |-> out_cls_o inside {OC_CMP, OC_TEST});

  p_legacy_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && (mode_i == FM_LEGACY) && long64_i |-> !out_fused_o);

  p_off_nofuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && (mode_i == FM_OFF) |-> !out_fused_o);

  p_flag_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !(out_fused_o && out_merge_o));
endmodule

bind mop_fuse_unit mop_fuse_unit_chk #(.TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .long64_i    (long64_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_cls_o   (out_cls_o),
  .out_cond_o  (out_cond_o),
  .out_tag_o   (out_tag_o),
  .out_jtag_o  (out_jtag_o),
  .out_fused_o (out_fused_o),
  .out_merge_o (out_merge_o)
);

// File: tb/mop_fuse_unit_tb_top.sv
`timescale 1ns/1ps
module mop_fuse_unit_tb_top;
  localparam int TW   = 8;
  localparam int MAXN = 1100;

  logic          clk, rst_n;
  logic [1:0]    mode;
  logic          long64;
  logic          in_valid, in_ready;
  logic [3:0]    in_cls, in_cond;
  logic [TW-1:0] in_tag;
  logic          out_valid, out_ready;
  logic [3:0]    out_cls, out_cond;
  logic [TW-1:0] out_tag, out_jtag;
  logic          out_fused, out_merge;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct { int cls; int cc; int tag; int gap; } item_t;
  item_t seq[MAXN];
  logic [25:0] ex[MAXN];
  int seq_n, ex_n;

  mop_fuse_unit #(.TAG_W(TW), .MERGE_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .long64_i(long64),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_cls_i(in_cls),
    .in_cond_i(in_cond), .in_tag_i(in_tag), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_cls_o(out_cls), .out_cond_o(out_cond),
    .out_tag_o(out_tag), .out_jtag_o(out_jtag), .out_fused_o(out_fused),
    .out_merge_o(out_merge)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
        finish_run();
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [25:0] pack(int c, int cc, int t, int jt, bit f, bit m);
    return {c[3:0], cc[3:0], t[7:0], jt[7:0], f, m};
  endfunction

  // requirement-level legality model
  function automatic bit m_fuse(int md, bit l64, int p, int cc);
    int fam = cc >> 1;
    bit ar = !(fam == 0 || fam == 4 || fam == 5);
    case (md)
      0: begin
        if (p == 1 || p == 2 || p == 3) return ar;
        if (p == 8 || p == 9) return 1'b1;
        if (p == 6 || p == 7) return (fam == 2 || fam == 6 || fam == 7);
        return 1'b0;
      end
      1: return (p == 1 || p == 8);
      2: return !l64 && (p == 1 || p == 8) && ar;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_merge(int p, int cc);
    int fam = cc >> 1;
    return (p == 6 || p == 7) && (fam == 1 || fam == 3);
  endfunction

  task automatic add_item(int c, int cc, int g);
    seq[seq_n] = '{c, cc, seq_n & 255, g};
    seq_n++;
  endtask

  task automatic build_expect(int md, bit l64);
    int i = 0;
    ex_n = 0;
    while (i < seq_n) begin
      item_t a = seq[i];
      if (i + 1 < seq_n && seq[i+1].cls == 15 && seq[i+1].gap == 0 &&
          m_fuse(md, l64, a.cls, seq[i+1].cc)) begin
        ex[ex_n++] = pack(a.cls, seq[i+1].cc, a.tag, seq[i+1].tag, 1, 0);
        i += 2;
      end else if (i + 1 < seq_n && seq[i+1].cls == 15 && seq[i+1].gap == 0 &&
                   m_merge(a.cls, seq[i+1].cc)) begin
        ex[ex_n++] = pack(a.cls, a.cc, a.tag, 0, 0, 0);
        ex[ex_n++] = pack(0, seq[i+1].cc, seq[i+1].tag, 0, 0, 1);
        ex[ex_n++] = pack(15, seq[i+1].cc, seq[i+1].tag, 0, 0, 0);
        i += 2;
      end else begin
        ex[ex_n++] = pack(a.cls, a.cc, a.tag, 0, 0, 0);
        i++;
      end
    end
  endtask

  // drives seq, collects output, compares against ex
  task automatic run_stream(int md, bit l64, bit bp, string req);
    int idx = 0;
    int got = 0;
    int n = 0;
    int gapc = (seq_n > 0) ? seq[0].gap : 0;
    bit prev_stall = 0;
    logic [25:0] prev_vec = '0;
    logic [25:0] vec;
    mode = md[1:0];
    long64 = l64;
    build_expect(md, l64);
    while (got < ex_n && n < 20000) begin
      @(negedge clk);
      if (gapc > 0) begin
        in_valid = 1'b0;
        gapc--;
      end else if (idx < seq_n) begin
        in_valid = 1'b1;
        in_cls = seq[idx].cls[3:0];
        in_cond = seq[idx].cc[3:0];
        in_tag = seq[idx].tag[7:0];
      end else begin
        in_valid = 1'b0;
      end
      out_ready = bp ? (($urandom % 4) != 0) : 1'b1;
      #2;
      vec = {out_cls, out_cond, out_tag, out_jtag, out_fused, out_merge};
      if (prev_stall)
        chk(out_valid && vec == prev_vec, "R13", "payload held under stall", {6'd0, vec}, {6'd0, prev_vec});
      prev_stall = out_valid && !out_ready;
      prev_vec = vec;
      if (out_valid && out_ready) begin
        chk(vec == ex[got], req, $sformatf("uop %0d", got), {6'd0, vec}, {6'd0, ex[got]});
        got++;
      end
      if (in_valid && in_ready) begin
        idx++;
        if (idx < seq_n) gapc = seq[idx].gap;
      end
      n++;
    end
    chk(got == ex_n, "R12", "uop count", got, ex_n);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      #2;
      chk(!out_valid, "R12", "no extra uop", out_valid, 0);
    end
    seq_n = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic sweep(int md, bit l64, bit bp, string req);
    seq_n = 0;
    for (int p = 0; p < 16; p++)
      for (int c = 0; c < 16; c++) begin
        add_item(p, 0, 0);
        add_item(15, c, 0);
      end
    run_stream(md, l64, bp, req);
  endtask

  task automatic t_full();   sweep(0, 0, 0, "R2,R3,R4,R5,R11"); endtask
  task automatic t_narrow(); sweep(1, 0, 0, "R6,R5"); endtask
  task automatic t_legacy(); sweep(2, 0, 0, "R7"); sweep(2, 1, 1, "R7"); endtask
  task automatic t_off();    sweep(3, 0, 0, "R8"); endtask

  task automatic t_gap();
    seq_n = 0;
    add_item(1, 0, 0);  add_item(15, 4, 2);   // cmp, late jz
    add_item(8, 0, 0);  add_item(15, 8, 1);   // test, late js
    add_item(7, 0, 0);  add_item(15, 2, 1);   // dec, late jc: no merge
    add_item(2, 0, 3);  add_item(15, 12, 0);  // add then jl, adjacent
    run_stream(0, 0, 0, "R9");
  endtask

  task automatic t_merge();
    for (int md = 0; md < 4; md++) begin
      seq_n = 0;
      add_item(6, 0, 0); add_item(15, 2, 0);  // inc, jc
      add_item(7, 0, 0); add_item(15, 6, 0);  // dec, ja family
      add_item(6, 0, 0); add_item(15, 3, 0);  // inc, jnc
      add_item(6, 0, 0); add_item(15, 8, 0);  // inc, js: no merge
      add_item(7, 0, 0); add_item(15, 4, 0);  // dec, jz
      run_stream(md, 0, md[0], "R10");
    end
  endtask

  task automatic t_chain();
    seq_n = 0;
    add_item(1, 0, 0); add_item(1, 0, 0); add_item(15, 4, 0);  // cmp cmp jz
    add_item(15, 4, 0); add_item(15, 5, 0);                    // jz jnz
    add_item(9, 0, 0); add_item(9, 0, 0); add_item(15, 10, 0); // and and jp
    add_item(0, 0, 0); add_item(15, 4, 0);                     // none, jz
    run_stream(0, 0, 0, "R11,R12");
  endtask

  task automatic t_mix();
    seq_n = 0;
    for (int i = 0; i < 600; i++) begin
      int c = (($urandom % 3) == 0) ? 15 : int'($urandom % 16);
      add_item(c, int'($urandom % 16), (($urandom % 5) == 0) ? 1 : 0);
    end
    run_stream(0, 0, 1, "R12,R13");
  endtask

  initial begin
    rst_n = 1'b0;
    mode = 2'd0;
    long64 = 1'b0;
    in_valid = 1'b0;
    in_cls = '0;
    in_cond = '0;
    in_tag = '0;
    out_ready = 1'b1;
    seq_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_narrow();
    t_legacy();
    t_off();
    t_gap();
    t_merge();
    t_chain();
    t_mix();
    finish_run();
  end
endmodule